// File: doc/BRIEF.md
# NAND Flash Host Cycle Interface

This block sits between a byte-wide host bus and one 8-bit raw NAND flash device. Every host access carries a 12-bit offset into a 4 KB window. The lower half of the window is a single data port, and any offset there turns one host byte into one flash data cycle. The upper half holds a control register, an odd-offset byte port for command and address bytes, and a status register. The flash pins are generated with setup, strobe-low and strobe-high widths that are set by parameters in clock counts.

Software drives a command sequence as follows. It writes the control register to select the device and to raise the command-latch or address-latch flag. It then writes each byte to the byte port and polls status until the busy bit is clear. Bulk data moves through the data window. The ready/busy line from the flash is synchronized. Its rising edge can raise an interrupt, and a status read clears that interrupt.

Top module: `nfc_host_bridge`

## Requirements
- R1: After reset the control register reads 0x01, the chip enable pin is high (inactive), WE# and RE# are high, CLE, ALE, the IO drive enable and irq are low, and wait is low.
- R2: A host write to any offset 0x000–0x7FF runs one flash write cycle. For that cycle IO carries the byte and CLE and ALE stay low. WE# is high for T_SETUP clocks, low for T_LOW clocks and high for T_HIGH clocks, and the cycle starts on the clock after the access is accepted.
- R3: A host read at any offset 0x000–0x7FF runs one flash read cycle with the same phase widths, with RE# low in place of WE#. Wait stays high for T_SETUP+T_LOW+T_HIGH+1 clocks. The returned byte is the IO input sampled on the last RE#-low clock.
- R4: A write to any even offset 0x800–0x80E loads the control register, and a read there returns it. In the control register, bit0 drives the chip enable pin (1 = inactive), bit1 is the command-latch flag, bit2 is the address-latch flag, bit3 enables the ready interrupt, and bit4 is a stored enable with no effect.
- R5: A write to any odd offset 0x801–0x80F runs one flash write cycle with the phase timing of R2. CLE and ALE copy control bit1 and bit2 as they were when the access was accepted, and they are held for the whole cycle.
- R6: Reading offset 0x810 returns the status byte. Bit3 is the synchronized ready line, bit2 is busy, bit1 is cycle complete and bit0 is the ready event. Busy is 1 from the clock after an access is accepted until the clock after that flash cycle ends.
- R7: A data-window access or a byte-port write that arrives while busy is held with wait high and is then executed, not dropped. The wait lasts until the clock on which the running cycle ends.
- R8: Cycle complete (status bit1) is set when any flash cycle ends. It is cleared by a status read, and a new completion in the same clock takes priority over the clear.
- R9: R/B# passes through two flops. Status bit3 shows a change of the pin after the second rising clock edge.
- R10: A rising edge of the synchronized ready line sets the ready event flag when control bit3 is 1. irq equals that flag, a status read clears it, and with bit3 at 0 the edge is ignored.
- R11: Control and status accesses never assert wait, including while a flash cycle runs.
- R12: WE# and RE# are never low together, and IO is driven only during write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_req | input | 1 | Host access request, held until wait is low |
| hb_we | input | 1 | 1 = write, 0 = read |
| hb_addr | input | 12 | Offset within the 4 KB window |
| hb_wdata | input | 8 | Host write byte |
| hb_rdata | output | 8 | Host read byte, valid when req is high and wait is low |
| hb_wait | output | 1 | Stall for the current access |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_io_out | output | 8 | Byte driven toward the flash |
| nand_io_oe | output | 1 | Drive enable for the IO pins |
| nand_io_in | input | 8 | Byte read from the IO pins |
| nand_rb_n | input | 1 | Ready/busy from flash, 1 = ready |
| irq | output | 1 | Ready interrupt |

## Verification
After a write is accepted, the bench waits until the next falling edge and then follows the flash pins one clock at a time. The first T_SETUP clocks are setup, the next T_LOW are strobe low and the next T_HIGH are strobe high, and the clock after that must be idle. A read is counted as T_SETUP+T_LOW+T_HIGH+1 wait clocks before its data is valid. A write presented on the clock after a byte-port write should see one clock fewer than a full cycle of wait, because the status read in between takes one clock. Ready status is sampled after the first and second edges following an R/B# change, and irq one edge later. Every sample is taken half a clock after the edge.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  typedef enum logic [2:0] {
    RG_DATA,
    RG_CTRL,
    RG_BYTE,
    RG_STAT,
    RG_NONE
  } nfc_region_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } nfc_phase_e;

  localparam int CTL_CE  = 0;
  localparam int CTL_CLE = 1;
  localparam int CTL_ALE = 2;
  localparam int CTL_RIE = 3;

  // Window decode: low 2 KB alias the data port, 0x800..0x80F split by offset parity
  function automatic nfc_region_e nfc_decode(input logic [11:0] a);
    if (!a[11])                 return RG_DATA;
    else if (a[11:4] == 8'h80)  return a[0] ? RG_BYTE : RG_CTRL;
    else if (a == 12'h810)      return RG_STAT;
    else                        return RG_NONE;
  endfunction

  function automatic logic [7:0] nfc_status(input logic rdy, input logic busy,
                                            input logic done, input logic evt);
    return {4'b0000, rdy, busy, done, evt};
  endfunction

  function automatic int nfc_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/nfc_rb_sync.sv
module nfc_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_n_i,
  output logic rdy_o,
  output logic rise_o
);
  logic [STAGES-1:0] sh_q;
  logic              rdy_d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      rdy_d_q <= 1'b0;
    end else begin
      sh_q    <= {sh_q[STAGES-2:0], rb_n_i};
      rdy_d_q <= sh_q[STAGES-1];
    end
  end

  assign rdy_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~rdy_d_q;
endmodule

// File: rtl/nfc_cycle_engine.sv
module nfc_cycle_engine
  import nfc_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HIGH  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       rd_i,
  input  logic       cle_i,
  input  logic       ale_i,
  input  logic [7:0] wdata_i,
  input  logic [7:0] io_in_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       we_n_o,
  output logic       re_n_o,
  output logic       cle_o,
  output logic       ale_o,
  output logic       io_oe_o,
  output logic [7:0] io_out_o,
  output logic [7:0] rdata_o
);
  localparam int MAXT  = nfc_max3(T_SETUP, T_LOW, T_HIGH);
  localparam int CNT_W = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(T_SETUP - 1);
  localparam logic [CNT_W-1:0] LD_LOW   = CNT_W'(T_LOW - 1);
  localparam logic [CNT_W-1:0] LD_HIGH  = CNT_W'(T_HIGH - 1);

  nfc_phase_e       ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_q, cle_q, ale_q;
  logic [7:0]       wd_q, rd_data_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      rd_q      <= 1'b0;
      cle_q     <= 1'b0;
      ale_q     <= 1'b0;
      wd_q      <= '0;
      rd_data_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_i) begin
          ph_q  <= PH_SETUP;
          cnt_q <= LD_SETUP;
          rd_q  <= rd_i;
          cle_q <= cle_i;
          ale_q <= ale_i;
          wd_q  <= wdata_i;
        end
        PH_SETUP: begin
          if (last) begin
            ph_q  <= PH_STROBE;
            cnt_q <= LD_LOW;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_STROBE: begin
          if (last) begin
            if (rd_q) rd_data_q <= io_in_i;
            ph_q  <= PH_HOLD;
            cnt_q <= LD_HIGH;
          end else cnt_q <= cnt_q - 1'b1;
        end
        PH_HOLD: begin
          if (last) ph_q <= PH_IDLE;
          else      cnt_q <= cnt_q - 1'b1;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o   = (ph_q != PH_IDLE);
  assign done_o   = (ph_q == PH_HOLD) && last;
  assign we_n_o   = ~((ph_q == PH_STROBE) && !rd_q);
  assign re_n_o   = ~((ph_q == PH_STROBE) && rd_q);
  assign cle_o    = busy_o & cle_q;
  assign ale_o    = busy_o & ale_q;
  assign io_oe_o  = busy_o & ~rd_q;
  assign io_out_o = wd_q;
  assign rdata_o  = rd_data_q;
endmodule

// File: rtl/nfc_host_bridge.sv
module nfc_host_bridge
  import nfc_pkg::*;
#(
  parameter int T_SETUP   = 2,
  parameter int T_LOW     = 3,
  parameter int T_HIGH    = 2,
  parameter int RB_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hb_req,
  input  logic        hb_we,
  input  logic [11:0] hb_addr,
  input  logic [7:0]  hb_wdata,
  output logic [7:0]  hb_rdata,
  output logic        hb_wait,
  output logic        nand_ce_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_io_out,
  output logic        nand_io_oe,
  input  logic [7:0]  nand_io_in,
  input  logic        nand_rb_n,
  output logic        irq
);
  nfc_region_e region;
  logic [7:0]  ctrl_q;
  logic        cmd_done_q, rdy_evt_q, rd_pend_q, rd_hold_q;
  logic        eng_busy, eng_done, eng_start, eng_cle, eng_ale;
  logic [7:0]  eng_rdata;
  logic        rdy_sync, rdy_rise;

  // Named internal events (used by the bound checker)
  logic        stall_grp, data_rd, accept, flash_wr_acc, start_rd, stat_rd, ctrl_wr;
  logic [7:0]  status;

  assign region       = nfc_decode(hb_addr);
  assign data_rd      = hb_req & ~hb_we & (region == RG_DATA);
  assign stall_grp    = (region == RG_DATA) | ((region == RG_BYTE) & hb_we);
  assign hb_wait      = hb_req & stall_grp & (eng_busy | (data_rd & ~rd_hold_q));
  assign accept       = hb_req & ~hb_wait;
  assign flash_wr_acc = accept & hb_we & stall_grp;
  assign start_rd     = data_rd & ~eng_busy & ~rd_hold_q;
  assign eng_start    = flash_wr_acc | start_rd;
  assign stat_rd      = accept & ~hb_we & (region == RG_STAT);
  assign ctrl_wr      = accept & hb_we & (region == RG_CTRL);
  assign eng_cle      = (region == RG_BYTE) & ctrl_q[CTL_CLE];
  assign eng_ale      = (region == RG_BYTE) & ctrl_q[CTL_ALE];
  assign status       = nfc_status(rdy_sync, eng_busy, cmd_done_q, rdy_evt_q);

  nfc_cycle_engine #(
    .T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HIGH(T_HIGH)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (eng_start),
    .rd_i     (start_rd),
    .cle_i    (eng_cle),
    .ale_i    (eng_ale),
    .wdata_i  (hb_wdata),
    .io_in_i  (nand_io_in),
    .busy_o   (eng_busy),
    .done_o   (eng_done),
    .we_n_o   (nand_we_n),
    .re_n_o   (nand_re_n),
    .cle_o    (nand_cle),
    .ale_o    (nand_ale),
    .io_oe_o  (nand_io_oe),
    .io_out_o (nand_io_out),
    .rdata_o  (eng_rdata)
  );

  nfc_rb_sync #(.STAGES(RB_STAGES)) u_rb (
    .clk    (clk),
    .rst_n  (rst_n),
    .rb_n_i (nand_rb_n),
    .rdy_o  (rdy_sync),
    .rise_o (rdy_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= 8'h01;
      cmd_done_q <= 1'b0;
      rdy_evt_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_hold_q  <= 1'b0;
    end else begin
      if (ctrl_wr) ctrl_q <= hb_wdata;

      if (eng_done)     cmd_done_q <= 1'b1;
      else if (stat_rd) cmd_done_q <= 1'b0;

      if (rdy_rise && ctrl_q[CTL_RIE]) rdy_evt_q <= 1'b1;
      else if (stat_rd)                rdy_evt_q <= 1'b0;

      if (start_rd)      rd_pend_q <= 1'b1;
      else if (eng_done) rd_pend_q <= 1'b0;

      if (eng_done && rd_pend_q)  rd_hold_q <= 1'b1;
      else if (data_rd && accept) rd_hold_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (region)
      RG_DATA: hb_rdata = eng_rdata;
      RG_CTRL: hb_rdata = ctrl_q;
      RG_STAT: hb_rdata = status;
      default: hb_rdata = 8'h00;
    endcase
  end

  assign nand_ce_n = ctrl_q[CTL_CE];
  assign irq       = rdy_evt_q;
endmodule

// File: rtl/nfc_host_bridge_chk.sv
module nfc_host_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        hb_req,
  input logic        hb_we,
  input logic [11:0] hb_addr,
  input logic        hb_wait,
  input logic        nand_we_n,
  input logic        nand_re_n,
  input logic        nand_cle,
  input logic        nand_ale,
  input logic        nand_io_oe,
  input logic        irq,
  input logic        eng_busy,
  input logic        eng_done,
  input logic        cmd_done_q,
  input logic        flash_wr_acc,
  input logic        ctrl_rie
);
  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  // R12
  drive_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_io_oe |-> nand_re_n);

  // R6
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> eng_busy);

  // R5
  latch_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nand_cle || nand_ale) |-> eng_busy);

  // R5
  latch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && $past(eng_busy)) |-> ($stable(nand_cle) && $stable(nand_ale)));

  // R7
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flash_wr_acc |-> !eng_busy);

  // R8
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> cmd_done_q);

  // R11
  reg_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_req && hb_addr[11] && !(hb_we && hb_addr[0] && hb_addr[11:4] == 8'h80))
      |-> !hb_wait);

  // R10
  irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_rie));
endmodule

bind nfc_host_bridge nfc_host_bridge_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hb_req       (hb_req),
  .hb_we        (hb_we),
  .hb_addr      (hb_addr),
  .hb_wait      (hb_wait),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_cle     (nand_cle),
  .nand_ale     (nand_ale),
  .nand_io_oe   (nand_io_oe),
  .irq          (irq),
  .eng_busy     (eng_busy),
  .eng_done     (eng_done),
  .cmd_done_q   (cmd_done_q),
  .flash_wr_acc (flash_wr_acc),
  .ctrl_rie     (ctrl_q[3])
);

// File: tb/nfc_host_bridge_tb.sv
`timescale 1ns/1ps
module nfc_host_bridge_tb_top;
  localparam int TS  = 2;
  localparam int TL  = 3;
  localparam int TH  = 2;
  localparam int TOT = TS + TL + TH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hb_req = 1'b0, hb_we = 1'b0;
  logic [11:0] hb_addr = '0;
  logic [7:0]  hb_wdata = '0;
  logic [7:0]  hb_rdata;
  logic        hb_wait;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe, irq;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in = '0;
  logic        nand_rb_n = 1'b1;

  int n_chk = 0, n_fail = 0, re_low = 0, n_reads = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nfc_host_bridge #(.T_SETUP(TS), .T_LOW(TL), .T_HIGH(TH)) dut_i (
    .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_rdata(hb_rdata), .hb_wait(hb_wait),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n), .irq(irq)
  );

  always @(negedge clk) if (rst_n && nand_re_n === 1'b0) re_low++;

  function automatic logic [7:0] exp_status(input bit rdy, input bit busy,
                                            input bit cc, input bit evt);
    exp_status = 8'h00;
    exp_status[3] = rdy; exp_status[2] = busy;
    exp_status[1] = cc;  exp_status[0] = evt;
  endfunction

  // phase index of clock i after acceptance: 0 setup, 1 strobe low, 2 strobe high
  function automatic int phase_at(input int i);
    if (i < TS) return 0;
    if (i < TS + TL) return 1;
    return 2;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [11:0] a, input logic [7:0] d,
                        output logic [7:0] q, output int nwait);
    @(negedge clk);
    hb_req = 1'b1; hb_we = we; hb_addr = a; hb_wdata = d;
    nwait = 0;
    #1;
    while (hb_wait) begin
      @(negedge clk); #1;
      nwait++;
    end
    q = hb_rdata;
    @(posedge clk); #1;
    hb_req = 1'b0;
  endtask

  task automatic check_wr_cycle(input string req, input logic [7:0] b,
                                input bit cle, input bit ale);
    bit ok = 1;
    for (int i = 0; i < TOT; i++) begin
      @(negedge clk); #1;
      if (nand_we_n !== (phase_at(i) != 1)) ok = 0;
      if (nand_re_n !== 1'b1 || nand_io_oe !== 1'b1 || nand_io_out !== b) ok = 0;
      if (nand_cle !== cle || nand_ale !== ale) ok = 0;
    end
    @(negedge clk); #1;
    if (nand_we_n !== 1'b1 || nand_io_oe !== 1'b0 || nand_cle || nand_ale) ok = 0;
    check(ok, req, "write cycle pins", nand_io_out, b);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    logic [7:0] q, b, v;
    int w;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset pins
    check(nand_ce_n === 1 && nand_we_n === 1 && nand_re_n === 1 && nand_cle === 0 &&
          nand_ale === 0 && nand_io_oe === 0 && irq === 0 && hb_wait === 0,
          "R1", "reset pins", {nand_ce_n, nand_we_n, nand_re_n, nand_io_oe, irq}, 5'b11100);
    access(0, 12'h800, 0, q, w);
    check(q === 8'h01, "R1", "reset control", q, 1);
    access(0, 12'h810, 0, q, w);
    check(q === exp_status(1, 0, 0, 0), "R6", "idle status", q, exp_status(1, 0, 0, 0));

    // R4 control register, chip enable pin
    access(1, 12'h80E, 8'h10, q, w);
    access(0, 12'h802, 0, q, w);
    check(q === 8'h10 && nand_ce_n === 0, "R4", "ctrl readback/ce", q, 8'h10);
    access(1, 12'h804, 8'h01, q, w);
    check(nand_ce_n === 1, "R4", "ce inactive", nand_ce_n, 1);
    access(1, 12'h800, 8'h00, q, w);

    // R2 data writes at both ends of the window
    access(1, 12'h000, 8'hA5, q, w);
    check_wr_cycle("R2", 8'hA5, 0, 0);
    access(1, 12'h7FF, 8'h3C, q, w);
    check_wr_cycle("R2", 8'h3C, 0, 0);

    // R8 cycle complete set then cleared by read
    access(0, 12'h810, 0, q, w);
    check(q === exp_status(1, 0, 1, 0), "R8", "complete set", q, exp_status(1, 0, 1, 0));
    access(0, 12'h810, 0, q, w);
    check(q === exp_status(1, 0, 0, 0), "R8", "complete cleared", q, exp_status(1, 0, 0, 0));

    // R5 command and address byte cycles
    access(1, 12'h800, 8'h02, q, w);
    access(1, 12'h801, 8'h70, q, w);
    check_wr_cycle("R5", 8'h70, 1, 0);
    access(1, 12'h806, 8'h04, q, w);
    access(1, 12'h80F, 8'h12, q, w);
    check_wr_cycle("R5", 8'h12, 0, 1);

    // R7 / R11 / R6 access while busy
    access(1, 12'h803, 8'h55, q, w);
    access(0, 12'h810, 0, q, w);
    check(w == 0 && q[2] === 1'b1, "R11", "status during cycle", {w, q}, 8'h04);
    access(1, 12'h123, 8'hC3, q, w);
    check(w == TOT - 1, "R7", "stall count", w, TOT - 1);
    check_wr_cycle("R7", 8'hC3, 0, 0);
    access(0, 12'h810, 0, q, w);
    check(q[2] === 1'b0, "R6", "busy cleared", q, 0);

    // R3 data reads
    for (int k = 0; k < 3; k++) begin
      v = 8'($urandom);
      nand_io_in = v;
      access(0, 12'($urandom % 2048), 0, q, w);
      n_reads++;
      check(q === v && w == TOT + 1, "R3", "read data/wait", {q, 8'(w)}, {v, 8'(TOT + 1)});
    end

    // constrained random mix
    for (int it = 0; it < 30; it++) begin
      int op = $urandom % 3;
      b = 8'($urandom);
      if (op == 0) begin
        access(1, 12'($urandom % 2048), b, q, w);
        check_wr_cycle("R2", b, 0, 0);
      end else if (op == 1) begin
        bit sel = 1'($urandom);
        access(1, 12'h800 + 12'(2 * ($urandom % 8)), sel ? 8'h04 : 8'h02, q, w);
        access(1, 12'h801 + 12'(2 * ($urandom % 8)), b, q, w);
        check_wr_cycle("R5", b, !sel, sel);
      end else begin
        nand_io_in = b;
        access(0, 12'($urandom % 2048), 0, q, w);
        n_reads++;
        check(q === b && w == TOT + 1, "R3", "random read", q, b);
      end
    end
    check(re_low == TL * n_reads, "R3", "RE# low clocks", re_low, TL * n_reads);

    // R9 synchronizer latency, status read presented continuously
    access(0, 12'h810, 0, q, w);
    @(negedge clk);
    hb_req = 1; hb_we = 0; hb_addr = 12'h810; nand_rb_n = 0;
    #1; b[0] = hb_rdata[3];
    @(negedge clk); #1; b[1] = hb_rdata[3];
    @(negedge clk); #1; b[2] = hb_rdata[3];
    hb_req = 0;
    check(b[2:0] === 3'b011, "R9", "ready sync latency", b[2:0], 3'b011);

    // R10 interrupt enabled
    access(1, 12'h800, 8'h08, q, w);
    @(negedge clk); nand_rb_n = 1;
    @(negedge clk); @(negedge clk); #1;
    check(irq === 0, "R10", "irq before third edge", irq, 0);
    @(negedge clk); #1;
    check(irq === 1, "R10", "irq set", irq, 1);
    access(0, 12'h810, 0, q, w);
    check(q === exp_status(1, 0, 0, 1), "R10", "event in status", q, exp_status(1, 0, 0, 1));
    @(negedge clk); #1;
    check(irq === 0, "R10", "irq cleared by read", irq, 0);

    // R10 interrupt disabled
    access(1, 12'h800, 8'h00, q, w);
    @(negedge clk); nand_rb_n = 0;
    repeat (4) @(negedge clk);
    nand_rb_n = 1;
    repeat (5) @(negedge clk);
    #1;
    check(irq === 0, "R10", "no irq when disabled", irq, 0);
    access(0, 12'h810, 0, q, w);
    check(q === exp_status(1, 0, 0, 0), "R10", "no event when disabled", q, exp_status(1, 0, 0, 0));

    finished = 1;
    summary();
  end
endmodule